// File: doc/BRIEF.md
# Asynchronous Serial Receive Channel with Break Detection

This block is the receive side of an asynchronous serial port. It watches a single serial input line, oversampled by a clock enable that pulses sixteen times per bit period. It finds the falling edge that opens a character and confirms it half a bit later, which filters out short glitches. It then takes each data bit near its centre, least-significant bit first, followed by an optional parity bit and one stop bit. The finished character goes into a one-entry holding register, together with per-character error flags and a sticky overrun flag.

A stop bit sampled low is reported in one of two ways. If every data and parity bit of that frame was zero, the line is taken to be held in the break condition. The block flags a received break and does not look for another character until the line returns high. Otherwise it flags a framing error. The host reads the character and then pulses a read strobe. An interrupt request follows the ready flag whenever it is enabled.

Top module: `async_rx_channel`

## Requirements
- R1: After a falling edge is seen on the synchronized line during a tick, the line is checked again 7 ticks later. If it is high at that point, the candidate is dropped, no character is produced and edge search resumes.
- R2: After a confirmed start, each bit is sampled every 16 ticks. Data bits are assembled least-significant bit first into `rx_data`.
- R3: `len_sel` selects the character length: 2'b00 = 5, 2'b01 = 6, 2'b10 = 7, 2'b11 = 8 data bits. Unused upper bits of `rx_data` read as zero.
- R4: When a character completes, `rx_data` and the flags are loaded and `rx_rdy` is set. `rx_irq` equals `rx_rdy` while `irq_en` is 1, and stays 0 while `irq_en` is 0.
- R5: `par_mode`: 2'b00 and 2'b01 mean no parity bit, 2'b10 means even parity and 2'b11 means odd parity. `rx_perr` is set for a character whose parity bit disagrees with the mode, and cleared for one that agrees or has no parity bit.
- R6: A stop bit sampled high returns the receiver at once to edge search, so a character that follows with no idle time is received correctly.
- R7: A stop bit sampled low, in a frame where some data or parity bit was 1, sets `rx_ferr` and clears `rx_brk`.
- R8: A stop bit sampled low, in a frame where all data and parity bits were 0, sets `rx_brk`, clears `rx_ferr` and `rx_perr`, and loads zero into `rx_data`.
- R9: After a break, no new character is started while the line stays low. The next character is received only after the line has gone high.
- R10: If a character completes while `rx_rdy` is still set and no read strobe arrives in that cycle, `rx_ovr` is set and the new character replaces the old one. A `rd_stb` pulse clears `rx_rdy` and `rx_ovr`.
- R11: While `rx_en` is 0, no character is received and any frame in progress is abandoned.
- R12: After reset, `rx_data`, `rx_rdy`, `rx_ferr`, `rx_perr`, `rx_brk`, `rx_ovr` and `rx_irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick16 | input | 1 | Oversampling enable, sixteen pulses per bit period |
| rxd | input | 1 | Serial input, asynchronous, idle high |
| rx_en | input | 1 | Receiver enable |
| len_sel | input | 2 | Character length select |
| par_mode | input | 2 | Parity mode select |
| irq_en | input | 1 | Interrupt request enable |
| rd_stb | input | 1 | Read strobe, one clock wide |
| rx_data | output | 8 | Holding register contents |
| rx_rdy | output | 1 | Character available |
| rx_ferr | output | 1 | Framing error on the held character |
| rx_perr | output | 1 | Parity error on the held character |
| rx_brk | output | 1 | Break received |
| rx_ovr | output | 1 | Overrun, sticky until read |
| rx_irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit maximum character, 16x oversampling and a two-stage synchronizer. It drives the tick every fourth clock, so one bit lasts 64 clocks. At these settings every length code from 5 to 8 bits can be exercised. A 5-tick low pulse falls inside the 7-tick confirmation window and must be rejected. Frames can be sent back to back to reach overrun and to confirm the immediate return to search after a good stop bit. With a 64-clock bit, a held-low line of twenty bit times fits easily within the run, which covers both the break report and the wait for the line to go high.

// File: rtl/srx_pkg.sv
// Shared types for the serial receive channel.
// Assumes: included before any module that uses rx_state_t or rx_flags_t.
package srx_pkg;

    typedef enum logic [2:0] {
        ST_WAITHI = 3'd0,   // line must be seen high before searching
        ST_HUNT   = 3'd1,   // looking for a low level on a tick
        ST_START  = 3'd2,   // confirming the start bit
        ST_DATA   = 3'd3,   // sampling data bits
        ST_PAR    = 3'd4,   // sampling the parity bit
        ST_STOP   = 3'd5    // sampling the stop bit
    } rx_state_t;

    typedef struct packed {
        logic ferr;
        logic perr;
        logic brk;
    } rx_flags_t;

endpackage

// File: rtl/srx_sync.sv
// Multi-stage synchronizer for the asynchronous serial input.
// Assumes: STAGES >= 2; resets to the idle (high) line level.
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain;

    // Shift the raw input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/srx_framer.sv
// Bit-level receive state machine: start confirmation, data, parity and
// stop sampling, break versus framing classification.
// Assumes: tick pulses OVS times per bit; rxd_s is already synchronized;
// length and parity settings are latched when a start edge is detected.
module srx_framer #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic                  en,
    input  logic                  rxd_s,
    input  logic [1:0]            len_sel,
    input  logic [1:0]            par_mode,
    output logic                  done_o,
    output logic [DATA_W-1:0]     data_o,
    output srx_pkg::rx_flags_t    flags_o
);
    import srx_pkg::*;

    localparam int CNT_W    = $clog2(OVS);
    localparam int IDX_W    = $clog2(DATA_W);
    localparam int MID      = OVS / 2 - 1;
    localparam int MIN_BITS = DATA_W - 3;

    rx_state_t          state;
    logic [CNT_W-1:0]   cnt;
    logic [IDX_W-1:0]   idx;
    logic [DATA_W-1:0]  shreg;
    logic [1:0]         cfg_len;
    logic [1:0]         cfg_par;
    logic               ones;
    logic               parbit;
    logic               any1;
    logic [IDX_W-1:0]   last_idx;
    logic               centre;
    logic               stop_low;
    logic               all_zero;

    // Index of the final data bit for the latched length.
    assign last_idx = IDX_W'(MIN_BITS - 1) + IDX_W'(cfg_len);
    // A tick that lands on a bit centre.
    assign centre   = (cnt == CNT_W'(OVS - 1));
    assign stop_low = !rxd_s;
    assign all_zero = !any1;

    // Main receive sequencer and character capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_WAITHI;
            cnt     <= '0;
            idx     <= '0;
            shreg   <= '0;
            cfg_len <= '0;
            cfg_par <= '0;
            ones    <= 1'b0;
            parbit  <= 1'b0;
            any1    <= 1'b0;
            done_o  <= 1'b0;
            data_o  <= '0;
            flags_o <= '0;
        end else begin
            done_o <= 1'b0;
            if (!en) begin
                state <= ST_WAITHI;
            end else if (tick) begin
                case (state)
                    ST_WAITHI: begin
                        if (rxd_s) state <= ST_HUNT;
                    end
                    ST_HUNT: begin
                        if (!rxd_s) begin
                            state   <= ST_START;
                            cnt     <= '0;
                            cfg_len <= len_sel;
                            cfg_par <= par_mode;
                        end
                    end
                    ST_START: begin
                        if (cnt == CNT_W'(MID - 1)) begin
                            cnt <= '0;
                            if (rxd_s) begin
                                state <= ST_HUNT;
                            end else begin
                                state  <= ST_DATA;
                                idx    <= '0;
                                shreg  <= '0;
                                ones   <= 1'b0;
                                parbit <= 1'b0;
                                any1   <= 1'b0;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (centre) begin
                            cnt        <= '0;
                            shreg[idx] <= rxd_s;
                            ones       <= ones ^ rxd_s;
                            any1       <= any1 | rxd_s;
                            if (idx == last_idx) state <= cfg_par[1] ? ST_PAR : ST_STOP;
                            else                 idx   <= idx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (centre) begin
                            cnt    <= '0;
                            parbit <= rxd_s;
                            any1   <= any1 | rxd_s;
                            state  <= ST_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (centre) begin
                            cnt          <= '0;
                            done_o       <= 1'b1;
                            data_o       <= shreg;
                            flags_o.brk  <= stop_low && all_zero;
                            flags_o.ferr <= stop_low && !all_zero;
                            flags_o.perr <= cfg_par[1] && ((ones ^ parbit) != cfg_par[0])
                                            && !(stop_low && all_zero);
                            state        <= (stop_low && all_zero) ? ST_WAITHI : ST_HUNT;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= ST_WAITHI;
                endcase
            end
        end
    end

    AST_START_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && state == ST_START && cnt == CNT_W'(MID - 1) && rxd_s) |=> (state == ST_HUNT)); // R1
    AST_NO_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAITHI && !rxd_s) |=> (state != ST_START)); // R9
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((data_o >> last_idx) <= DATA_W'(1))); // R3
    AST_DONE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(en)); // R11

endmodule

// File: rtl/srx_hold.sv
// One-entry receive holding register with ready, error and overrun flags.
// Assumes: done_i is a one-clock pulse; rd_stb is one clock wide.
module srx_hold #(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  done_i,
    input  logic [DATA_W-1:0]     data_i,
    input  srx_pkg::rx_flags_t    flags_i,
    input  logic                  rd_stb,
    input  logic                  irq_en,
    output logic [DATA_W-1:0]     rx_data,
    output logic                  rdy,
    output logic                  ferr,
    output logic                  perr,
    output logic                  brk,
    output logic                  ovr,
    output logic                  irq
);

    // Load a finished character or retire the held one on a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0;
            rdy     <= 1'b0;
            ferr    <= 1'b0;
            perr    <= 1'b0;
            brk     <= 1'b0;
            ovr     <= 1'b0;
        end else if (done_i) begin
            rx_data <= data_i;
            ferr    <= flags_i.ferr;
            perr    <= flags_i.perr;
            brk     <= flags_i.brk;
            rdy     <= 1'b1;
            ovr     <= (ovr || rdy) && !rd_stb;
        end else if (rd_stb) begin
            rdy <= 1'b0;
            ovr <= 1'b0;
        end
    end

    // Interrupt request follows the ready flag when enabled.
    assign irq = rdy & irq_en;

    AST_RDY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> rdy); // R4
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !done_i) |=> (!rdy && !ovr)); // R10
    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && rdy && !rd_stb) |=> ovr); // R10
    AST_BRK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        brk |-> (rx_data == '0 && !ferr)); // R8

endmodule

// File: rtl/async_rx_channel.sv
// Top of the serial receive channel: synchronizer, bit framer and
// holding register.
// Assumes: tick16 is a single-clock enable at OVS times the bit rate.
module async_rx_channel #(
    parameter int DATA_W      = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              rxd,
    input  logic              rx_en,
    input  logic [1:0]        len_sel,
    input  logic [1:0]        par_mode,
    input  logic              irq_en,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_rdy,
    output logic              rx_ferr,
    output logic              rx_perr,
    output logic              rx_brk,
    output logic              rx_ovr,
    output logic              rx_irq
);

    logic                rxd_s;
    logic                done;
    logic [DATA_W-1:0]   chr;
    srx_pkg::rx_flags_t  flg;

    srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (rxd),
        .q_sync  (rxd_s)
    );

    srx_framer #(.DATA_W(DATA_W), .OVS(OVS)) u_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick16),
        .en       (rx_en),
        .rxd_s    (rxd_s),
        .len_sel  (len_sel),
        .par_mode (par_mode),
        .done_o   (done),
        .data_o   (chr),
        .flags_o  (flg)
    );

    srx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .done_i  (done),
        .data_i  (chr),
        .flags_i (flg),
        .rd_stb  (rd_stb),
        .irq_en  (irq_en),
        .rx_data (rx_data),
        .rdy     (rx_rdy),
        .ferr    (rx_ferr),
        .perr    (rx_perr),
        .brk     (rx_brk),
        .ovr     (rx_ovr),
        .irq     (rx_irq)
    );

endmodule

// File: tb/tb_async_rx_channel.sv
module tb_async_rx_channel;

    localparam int BIT_CLKS = 64;   // 16 ticks x 4 clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic       rx_en = 1'b0;
    logic [1:0] len_sel = 2'b11;
    logic [1:0] par_mode = 2'b00;
    logic       irq_en = 1'b0;
    logic       rd_stb = 1'b0;
    logic [7:0] rx_data;
    logic       rx_rdy, rx_ferr, rx_perr, rx_brk, rx_ovr, rx_irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [1:0] tdiv = 2'd0;

    async_rx_channel dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .rx_en(rx_en),
        .len_sel(len_sel), .par_mode(par_mode), .irq_en(irq_en), .rd_stb(rd_stb),
        .rx_data(rx_data), .rx_rdy(rx_rdy), .rx_ferr(rx_ferr), .rx_perr(rx_perr),
        .rx_brk(rx_brk), .rx_ovr(rx_ovr), .rx_irq(rx_irq)
    );

    always #5 clk = ~clk;

    // Tick every fourth clock.
    always @(posedge clk) begin
        tdiv   <= tdiv + 2'd1;
        tick16 <= (tdiv == 2'd3);
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hold_line(input logic v, input int bits);
        rxd = v;
        repeat (bits * BIT_CLKS) @(negedge clk);
    endtask

    // Send one frame; flip_par inverts the parity bit.
    task automatic send_char(input logic [7:0] d, input int nb, input logic [1:0] pm,
                             input logic stopv, input logic flip_par);
        logic p;
        p = 1'b0;
        for (int i = 0; i < nb; i++) p = p ^ d[i];
        if (pm[0]) p = ~p;
        p = p ^ flip_par;
        hold_line(1'b0, 1);
        for (int i = 0; i < nb; i++) hold_line(d[i], 1);
        if (pm[1]) hold_line(p, 1);
        hold_line(stopv, 1);
        rxd = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic do_read;
        @(negedge clk); rd_stb = 1'b1;
        @(negedge clk); rd_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R12 data", rx_data, 8'h00);
        chk("R12 flags", {rx_rdy, rx_ferr, rx_perr, rx_brk, rx_ovr, rx_irq}, 6'b0);
    endtask

    task automatic t_basic;
        len_sel = 2'b11; par_mode = 2'b00; irq_en = 1'b1;
        send_char(8'hA5, 8, 2'b00, 1'b1, 1'b0);
        chk("R2 data lsb first", rx_data, 8'hA5);
        chk("R4 rdy", rx_rdy, 1'b1);
        chk("R4 irq", rx_irq, 1'b1);
        chk("R7 no ferr", rx_ferr, 1'b0);
        irq_en = 1'b0;
        @(negedge clk);
        chk("R4 irq gated", rx_irq, 1'b0);
        do_read;
        chk("R10 read clears rdy", rx_rdy, 1'b0);
    endtask

    task automatic t_lengths;
        len_sel = 2'b00;
        send_char(8'h15, 5, 2'b00, 1'b1, 1'b0);
        chk("R3 len5 data", rx_data, 8'h15);
        do_read;
        len_sel = 2'b01;
        send_char(8'h2A, 6, 2'b00, 1'b1, 1'b0);
        chk("R3 len6 data", rx_data, 8'h2A);
        do_read;
        len_sel = 2'b10;
        send_char(8'h7F, 7, 2'b00, 1'b1, 1'b0);
        chk("R3 len7 data", rx_data, 8'h7F);
        do_read;
        len_sel = 2'b11;
    endtask

    task automatic t_parity;
        par_mode = 2'b10;
        send_char(8'h37, 8, 2'b10, 1'b1, 1'b0);
        chk("R5 even ok", {rx_perr, rx_data}, {1'b0, 8'h37});
        do_read;
        send_char(8'h37, 8, 2'b10, 1'b1, 1'b1);
        chk("R5 even bad", {rx_perr, rx_data}, {1'b1, 8'h37});
        do_read;
        par_mode = 2'b11;
        send_char(8'hC3, 8, 2'b11, 1'b1, 1'b0);
        chk("R5 odd ok", {rx_perr, rx_data}, {1'b0, 8'hC3});
        do_read;
        send_char(8'hC3, 8, 2'b11, 1'b1, 1'b1);
        chk("R5 odd bad", rx_perr, 1'b1);
        do_read;
        par_mode = 2'b00;
    endtask

    task automatic t_glitch;
        rxd = 1'b0;
        repeat (20) @(negedge clk);
        rxd = 1'b1;
        repeat (12 * BIT_CLKS) @(negedge clk);
        chk("R1 glitch rejected", rx_rdy, 1'b0);
        send_char(8'h3C, 8, 2'b00, 1'b1, 1'b0);
        chk("R1 search resumes", {rx_rdy, rx_data}, {1'b1, 8'h3C});
        do_read;
    endtask

    task automatic t_overrun;
        send_char(8'h11, 8, 2'b00, 1'b1, 1'b0);
        chk("R10 no ovr yet", rx_ovr, 1'b0);
        send_char(8'h22, 8, 2'b00, 1'b1, 1'b0);
        chk("R6 back to back data", rx_data, 8'h22);
        chk("R10 ovr set", rx_ovr, 1'b1);
        do_read;
        chk("R10 read clears ovr", {rx_rdy, rx_ovr}, 2'b00);
    endtask

    task automatic t_framing;
        send_char(8'h55, 8, 2'b00, 1'b0, 1'b0);
        chk("R7 ferr", {rx_ferr, rx_brk}, 2'b10);
        chk("R7 data", rx_data, 8'h55);
        do_read;
    endtask

    task automatic t_break;
        hold_line(1'b0, 20);
        chk("R8 brk flags", {rx_rdy, rx_brk, rx_ferr, rx_perr}, 4'b1100);
        chk("R8 data zero", rx_data, 8'h00);
        do_read;
        hold_line(1'b0, 15);
        chk("R9 no start while low", rx_rdy, 1'b0);
        hold_line(1'b1, 2);
        send_char(8'h5A, 8, 2'b00, 1'b1, 1'b0);
        chk("R9 resume after high", {rx_rdy, rx_brk, rx_data}, {2'b10, 8'h5A});
        do_read;
    endtask

    task automatic t_disabled;
        @(negedge clk); rx_en = 1'b0;
        send_char(8'h77, 8, 2'b00, 1'b1, 1'b0);
        chk("R11 disabled no char", rx_rdy, 1'b0);
        rx_en = 1'b1;
        hold_line(1'b1, 1);
        chk("R11 still none", rx_rdy, 1'b0);
        send_char(8'h66, 8, 2'b00, 1'b1, 1'b0);
        chk("R11 enabled again", {rx_rdy, rx_data}, {1'b1, 8'h66});
        do_read;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        rx_en = 1'b1;
        repeat (2 * BIT_CLKS) @(negedge clk);
        t_basic;
        t_lengths;
        t_parity;
        t_glitch;
        t_overrun;
        t_framing;
        t_break;
        t_disabled;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule